// File: doc/BRIEF.md
# Serial ADC Conversion Frame Master

This block is the host side of a four-wire link to a successive-approximation converter. When a start request arrives it captures a channel number, an input-mode flag and a power-down code. It pulls chip select low and produces the serial clock from the system clock. Each conversion is one fixed frame of 24 serial clocks. The first eight clocks carry a command byte. The converter sends its 16-bit result back while the later clocks are running, so the command and the answer share a single frame and are not separate exchanges.

The serial clock comes from a divider. Each half period lasts `half_div + 1` system clocks, and that value is latched when the request is accepted. Chip select stays low for one half period before the first rising edge, and stays low for one half period after the last falling edge. The master then shows the finished word with a one-cycle strobe. In that same strobe cycle it can accept the next request.

Top module: `adc_frame_host`

## Requirements
- R1: While `rst_n` is low and after reset, `cs_n`=1, `dclk`=0, `din`=0, `busy`=0, `result_valid`=0 and `result`=0.
- R2: Each `dclk` half period lasts `half_div+1` system clocks. `dclk` is low whenever the block is idle, and each frame has exactly 24 rising edges.
- R3: `cs_n` goes low in the cycle after a start is accepted. It stays low through one low half period before the first rising edge, through the 24 clocks, and through one more low half period after the 24th falling edge.
- R4: The command byte is {1, channel[2:0], 0, single_ended, pd_mode[1:0]}, with bit 7 first. Bit 7-j is on `din` before the (j+1)th rising edge. `din` changes only when `dclk` falls, and it is 0 after the eighth bit.
- R5: `dout` is sampled at the system edge that raises `dclk`. Rising edges 9 to 24 carry result bits 15 down to 0. Samples taken at edges 1 to 8 are discarded.
- R6: `result_valid` is a one-cycle pulse in the first cycle that `cs_n` is high again. `result` takes its new value in that cycle and holds it until the next pulse.
- R7: `busy` is high from the cycle after acceptance up to the strobe, and it is low in the strobe cycle. It stays high for exactly 49*(half_div+1) cycles.
- R8: A start request that arrives while `busy` is high is ignored. So are changes to `channel`, `single_ended` or `pd_mode` during a frame. The running frame and its result are not affected.
- R9: A start request that is present in the strobe cycle is accepted, so `busy` is high again in the next cycle.
- R10: A change to `half_div` after acceptance does not alter the current frame's timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Conversion request, taken when idle |
| channel | input | 3 | Channel select code |
| single_ended | input | 1 | 1 = single-ended input, 0 = differential |
| pd_mode | input | 2 | Power-down code placed in the command byte |
| half_div | input | 8 | Serial clock half period minus one, in system clocks |
| dout | input | 1 | Serial data from the converter |
| cs_n | output | 1 | Active-low chip select |
| dclk | output | 1 | Serial clock |
| din | output | 1 | Serial command data to the converter |
| busy | output | 1 | A frame is in progress |
| result_valid | output | 1 | One-cycle strobe marking a fresh result |
| result | output | 16 | Last captured conversion word |

## Verification
Two things can happen in the same cycle: the strobe that ends a frame and the acceptance of the next request. The bench provokes this by holding `start` high through a whole frame. The block must ignore the request while busy, then take it in the strobe cycle and raise `busy` again on the next cycle, while the previous word stays stable in `result`. A behavioural model of the converter and the host checks every output on every clock, including this back-to-back frame.

// File: rtl/adcf_pkg.sv
package adcf_pkg;
  localparam int CMD_BITS    = 8;
  localparam int RES_BITS    = 16;
  localparam int FRAME_EDGES = 24;
  localparam int CH_W        = 3;
  localparam int PD_W        = 2;
  localparam int EDGE_W      = $clog2(FRAME_EDGES + 1);

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_LEAD,
    SQ_HIGH,
    SQ_LOW,
    SQ_TAIL
  } seq_state_e;

  // Command byte: start marker, channel code, zero, mode flag, power-down code
  function automatic logic [CMD_BITS-1:0] make_cmd(input logic [CH_W-1:0] ch,
                                                   input logic se,
                                                   input logic [PD_W-1:0] pd);
    return {1'b1, ch, 1'b0, se, pd};
  endfunction

  // Busy length of one frame: lead half, 24 high, 23 inner low, tail half
  function automatic int unsigned frame_cycles(input int unsigned hdiv);
    return (2 * FRAME_EDGES + 1) * (hdiv + 1);
  endfunction
endpackage

// File: rtl/adcf_half_timer.sv
module adcf_half_timer #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [DIV_W-1:0] div_in,
  input  logic             run,
  output logic             tick,
  output logic [DIV_W-1:0] div_q
);
  logic [DIV_W-1:0] cnt;

  assign tick = run && (cnt == div_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      div_q <= '0;
    end else if (load) begin
      cnt   <= '0;
      div_q <= div_in;
    end else if (run) begin
      cnt <= tick ? '0 : cnt + 1'b1;
    end
  end
endmodule

// File: rtl/adcf_sequencer.sv
module adcf_sequencer
  import adcf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              tick,
  output logic              accept,
  output logic              run,
  output logic              rise_evt,
  output logic              fall_evt,
  output logic              tail_done,
  output logic [EDGE_W-1:0] edge_cnt,
  output logic              dclk,
  output logic              cs_n,
  output logic              busy,
  output logic              valid
);
  seq_state_e state, state_d;
  logic       last_edge;

  assign last_edge = (edge_cnt == EDGE_W'(FRAME_EDGES));
  assign accept    = (state == SQ_IDLE) && start;
  assign run       = (state != SQ_IDLE);
  assign rise_evt  = tick && ((state == SQ_LEAD) || (state == SQ_LOW));
  assign fall_evt  = tick && (state == SQ_HIGH);
  assign tail_done = tick && (state == SQ_TAIL);

  always_comb begin
    state_d = state;
    case (state)
      SQ_IDLE: if (start) state_d = SQ_LEAD;
      SQ_LEAD: if (tick) state_d = SQ_HIGH;
      SQ_HIGH: if (tick) state_d = last_edge ? SQ_TAIL : SQ_LOW;
      SQ_LOW:  if (tick) state_d = SQ_HIGH;
      SQ_TAIL: if (tick) state_d = SQ_IDLE;
      default: state_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= SQ_IDLE;
      dclk     <= 1'b0;
      cs_n     <= 1'b1;
      busy     <= 1'b0;
      valid    <= 1'b0;
      edge_cnt <= '0;
    end else begin
      state <= state_d;
      dclk  <= (state_d == SQ_HIGH);
      cs_n  <= (state_d == SQ_IDLE);
      busy  <= (state_d != SQ_IDLE);
      valid <= tail_done;
      if (accept)        edge_cnt <= '0;
      else if (rise_evt) edge_cnt <= edge_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/adcf_cmd_shifter.sv
module adcf_cmd_shifter #(
  parameter int BITS = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [BITS-1:0] word,
  input  logic            shift,
  output logic            ser_out
);
  logic [BITS-1:0] sh;

  assign ser_out = sh[BITS-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sh <= '0;
    else if (load)  sh <= word;
    else if (shift) sh <= {sh[BITS-2:0], 1'b0};
  end
endmodule

// File: rtl/adcf_res_capture.sv
module adcf_res_capture #(
  parameter int BITS = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sample,
  input  logic            ser_in,
  input  logic            commit,
  output logic [BITS-1:0] word
);
  logic [BITS-1:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh   <= '0;
      word <= '0;
    end else begin
      if (sample) sh <= {sh[BITS-2:0], ser_in};
      if (commit) word <= sh;
    end
  end
endmodule

// File: rtl/adc_frame_host.sv
module adc_frame_host
  import adcf_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [CH_W-1:0]     channel,
  input  logic                single_ended,
  input  logic [PD_W-1:0]     pd_mode,
  input  logic [DIV_W-1:0]    half_div,
  input  logic                dout,
  output logic                cs_n,
  output logic                dclk,
  output logic                din,
  output logic                busy,
  output logic                result_valid,
  output logic [RES_BITS-1:0] result
);
  logic              accept, run, tick;
  logic              rise_evt, fall_evt, tail_done;
  logic [EDGE_W-1:0] edge_cnt;
  logic [DIV_W-1:0]  div_q;

  adcf_half_timer #(.DIV_W(DIV_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(accept), .div_in(half_div),
    .run(run), .tick(tick), .div_q(div_q)
  );

  adcf_sequencer u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .tick(tick),
    .accept(accept), .run(run), .rise_evt(rise_evt), .fall_evt(fall_evt),
    .tail_done(tail_done), .edge_cnt(edge_cnt), .dclk(dclk), .cs_n(cs_n),
    .busy(busy), .valid(result_valid)
  );

  adcf_cmd_shifter #(.BITS(CMD_BITS)) u_cmd (
    .clk(clk), .rst_n(rst_n), .load(accept),
    .word(make_cmd(channel, single_ended, pd_mode)),
    .shift(fall_evt), .ser_out(din)
  );

  adcf_res_capture #(.BITS(RES_BITS)) u_res (
    .clk(clk), .rst_n(rst_n), .sample(rise_evt), .ser_in(dout),
    .commit(tail_done), .word(result)
  );
endmodule

// File: rtl/adcf_checker.sv
module adcf_checker
  import adcf_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                start,
  input logic                accept,
  input logic                busy,
  input logic                cs_n,
  input logic                dclk,
  input logic                din,
  input logic                valid,
  input logic [RES_BITS-1:0] result,
  input logic [EDGE_W-1:0]   edge_cnt,
  input logic [DIV_W-1:0]    div_q
);
  logic [31:0] blen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      blen <= '0;
    else if (accept) blen <= '0;
    else if (busy)   blen <= blen + 1;
  end

  assert_idle_clk_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !dclk);
  assert_edge_total_R2: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> (edge_cnt == EDGE_W'(FRAME_EDGES)));
  assert_cs_in_frame_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |-> busy);
  assert_din_on_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    dclk |-> $stable(din));
  assert_strobe_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    valid |=> !valid);
  assert_result_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |-> $stable(result));
  assert_busy_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> valid);
  assert_frame_len_R7: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> (blen == frame_cycles(32'(div_q))));
  assert_accept_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> !busy);
  assert_back_to_back_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && start) |=> busy);
  assert_div_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(div_q));
endmodule

bind adc_frame_host adcf_checker #(.DIV_W(DIV_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .accept(accept), .busy(busy),
  .cs_n(cs_n), .dclk(dclk), .din(din), .valid(result_valid), .result(result),
  .edge_cnt(edge_cnt), .div_q(div_q)
);

// File: tb/adc_frame_host_bench.sv
module adc_frame_host_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  channel = '0;
  logic        single_ended = 1'b0;
  logic [1:0]  pd_mode = '0;
  logic [7:0]  half_div = '0;
  logic        dout = 1'b1;
  logic        cs_n, dclk, din, busy, result_valid;
  logic [15:0] result;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;

  // model state: 0 idle, 1 in frame, 2 strobe cycle
  int          m_mode = 0;
  int          m_t = 0;
  int          m_h = 1;
  logic [7:0]  m_cmd = '0;
  logic [15:0] m_pat = '0;
  logic [15:0] m_res = '0;
  logic [15:0] next_pat = '0;

  adc_frame_host u_adc_frame_host (
    .clk(clk), .rst_n(rst_n), .start(start), .channel(channel),
    .single_ended(single_ended), .pd_mode(pd_mode), .half_div(half_div),
    .dout(dout), .cs_n(cs_n), .dclk(dclk), .din(din), .busy(busy),
    .result_valid(result_valid), .result(result)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  // model state update, reads inputs that only change at negedge
  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      m_mode = 0; m_res = '0;
    end else if (m_mode == 1) begin
      if (m_t == 49 * m_h - 1) begin
        m_mode = 2; m_res = m_pat;
      end else m_t++;
    end else if (start) begin
      m_mode = 1; m_t = 0; m_h = int'(half_div) + 1;
      m_cmd = {1'b1, channel, 1'b0, single_ended, pd_mode};
      m_pat = next_pat;
    end else m_mode = 0;
  end

  // compare every cycle and play the converter
  always @(negedge clk) begin
    if (rst_n) begin
      int h;
      logic e_dclk, e_din;
      h = m_t / m_h;
      if (m_mode == 1) begin
        e_dclk = (h % 2) == 1;
        e_din  = (h / 2 < 8) ? m_cmd[7 - h / 2] : 1'b0;
      end else begin
        e_dclk = 1'b0; e_din = 1'b0;
      end
      check("R3 cs_n", {15'd0, cs_n}, {15'd0, m_mode != 1});
      check("R7 busy", {15'd0, busy}, {15'd0, m_mode == 1});
      check("R2 dclk", {15'd0, dclk}, {15'd0, e_dclk});
      check("R4 din", {15'd0, din}, {15'd0, e_din});
      check("R6 result_valid", {15'd0, result_valid}, {15'd0, m_mode == 2});
      check("R5 result", result, m_res);
      // R5: bit for rising edge k (9..24) is driven through the low half before it
      if (m_mode == 1 && (h % 2) == 0 && h >= 16 && h <= 46)
        dout = m_pat[24 - (h / 2 + 1)];
      else
        dout = 1'b1;
    end
  end

  task automatic run_frame(input logic [2:0] c, input logic s, input logic [1:0] p,
                           input logic [7:0] d, input logic [15:0] pat,
                           input bit disturb, input bit hold, input logic [15:0] pat2);
    int bl;
    @(negedge clk);
    channel = c; single_ended = s; pd_mode = p; half_div = d; next_pat = pat;
    start = 1'b1;
    bl = 0;
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (!hold) start = 1'b0;
      if (hold) next_pat = pat2;
      if (disturb && (i == 3 || i == 40 || i == 97)) begin
        start = 1'b1; half_div = d + 8'd3; channel = ~c;
        single_ended = ~s; pd_mode = ~p;
      end
      if (result_valid) break;
      if (busy) bl++;
    end
    check(disturb ? "R8 result after ignored starts" : "R5 result", result, pat);
    check(disturb ? "R10 frame length" : "R7 frame length", 16'(bl), 16'(49 * (int'(d) + 1)));
    if (hold) begin
      @(negedge clk);
      check("R9 busy after strobe-cycle start", {15'd0, busy}, 16'd1);
      start = 1'b0;
      for (int i = 0; i < 20000; i++) begin
        @(negedge clk);
        if (result_valid) break;
      end
      check("R9 second result", result, pat2);
    end
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 cs_n", {15'd0, cs_n}, 16'd1);
    check("R1 dclk", {15'd0, dclk}, 16'd0);
    check("R1 din", {15'd0, din}, 16'd0);
    check("R1 busy", {15'd0, busy}, 16'd0);
    check("R1 result_valid", {15'd0, result_valid}, 16'd0);
    check("R1 result", result, 16'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    run_frame(3'd5, 1'b1, 2'b11, 8'd0, 16'hA5C3, 1'b0, 1'b0, 16'h0);
    run_frame(3'd2, 1'b0, 2'b00, 8'd1, 16'hFFFF, 1'b0, 1'b0, 16'h0);
    run_frame(3'd7, 1'b1, 2'b01, 8'd3, 16'h0000, 1'b0, 1'b0, 16'h0);
    run_frame(3'd0, 1'b0, 2'b10, 8'd2, 16'h8001, 1'b0, 1'b0, 16'h0);
    run_frame(3'd6, 1'b0, 2'b01, 8'd1, 16'h3C5A, 1'b1, 1'b0, 16'h0);
    run_frame(3'd1, 1'b1, 2'b10, 8'd0, 16'h1234, 1'b0, 1'b1, 16'hFEDC);
    repeat (5) @(negedge clk);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule